// File: doc/BRIEF.md
# Copy-Scratchpad Authorization Controller

This block carries out the copy-scratchpad command at byte level. Once the host has sent the copy command code, it must send back three bytes: the target address low byte, the target address high byte, and the ending-offset/status byte. These bytes must match the block's address registers exactly. If all three match, the block sets an authorization-accepted flag. It then moves scratchpad bytes into main memory, one byte per clock, from the starting offset through the ending offset. The first byte goes to the full 16-bit target address.

If any byte differs, or the command code is not the copy code, the block copies nothing. It then waits for a bus reset. After a copy has finished, every host read request returns the alternating pattern 0xAA until the host issues a bus reset. A bus reset that arrives while the copy is running has no effect. The flag remains set until the next write-scratchpad command.

Top module: `copy_auth_ctrl`

## Requirements
- R1: After `rst_n` is deasserted, `busy`, `auth_ok`, `mem_we` and `tx_valid` are all 0.
- R2: Only the command byte 0x55 leads to authorization. Any other first byte after a bus reset produces no memory writes, even if a correct echo follows, until the next `bus_reset`.
- R3: The three bytes after the command are compared with `tgt_lo`, then `tgt_hi`, then `{auth_ok, es_reg[6:0]}`, in that order. Any mismatch ends the command with no memory write and leaves `auth_ok` unchanged.
- R4: When the third byte matches, `auth_ok` goes to 1 at the following clock edge. `busy` and `mem_we` are high from then until the copy ends.
- R5: The starting offset is `tgt_lo[4:0]` and the ending offset is `es_reg[4:0]`. The copy writes ((end - start) mod 32) + 1 bytes. Write k (counting from 0) puts scratchpad byte (start + k) mod 32 at memory address `{tgt_hi,tgt_lo}` + k.
- R6: `bus_reset` is ignored while `busy` is high. The copy runs to its full length.
- R7: A `tx_req` pulse produces one cycle later a `tx_valid` pulse with `tx_byte`. `tx_byte` is 0xAA after a completed copy and 0xFF in every other state. The 0xAA reply continues until `bus_reset`.
- R8: `auth_ok` stays at 1 across bus resets. Only `sp_wr_cmd` clears it, and `sp_wr_cmd` is ignored while `busy` is high.
- R9: When `auth_ok` is already 1, bit 7 of the third echo byte must be 1 for the command to be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| bus_reset | input | 1 | Host bus-reset strobe |
| rx_valid | input | 1 | Host byte strobe |
| rx_byte | input | 8 | Byte from host |
| tx_req | input | 1 | Host read request |
| tx_valid | output | 1 | Reply byte valid |
| tx_byte | output | 8 | Reply byte to host |
| tgt_lo | input | 8 | Target address low register |
| tgt_hi | input | 8 | Target address high register |
| es_reg | input | 7 | Ending-offset/status bits 6:0 |
| sp_wr_cmd | input | 1 | Write-scratchpad command strobe |
| sp_addr | output | 5 | Scratchpad read offset |
| sp_data | input | 8 | Scratchpad read data (combinational) |
| mem_addr | output | 16 | Memory write address |
| mem_data | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| busy | output | 1 | Copy in progress |
| auth_ok | output | 1 | Authorization-accepted flag |

## Verification
The echo is tried in several forms:
- A full page.
- A single byte with equal offsets.
- A copy that wraps the scratchpad offset.
- A copy at the top address.
- An end byte with bits 6:5 set.
- A wrong byte at each of the three positions, which shows whether the comparison covers each register and keeps the right order.

A wrong command code shows that only 0x55 opens the sequence. An echo with the flag bit shows that the live flag takes part in the comparison. A bus reset pulsed in the middle of a long copy separates a true lockout from an aborted copy.

// File: rtl/copy_auth_ctrl.sv
module copy_auth_ctrl #(
  parameter logic [7:0] CMD_CODE = 8'h55,
  parameter int AW = 16,
  parameter int OW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_reset,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic          tx_req,
  output logic          tx_valid,
  output logic [7:0]    tx_byte,
  input  logic [7:0]    tgt_lo,
  input  logic [7:0]    tgt_hi,
  input  logic [6:0]    es_reg,
  input  logic          sp_wr_cmd,
  output logic [OW-1:0] sp_addr,
  input  logic [7:0]    sp_data,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_data,
  output logic          mem_we,
  output logic          busy,
  output logic          auth_ok
);
  localparam logic [7:0] PATTERN = 8'hAA;
  localparam logic [7:0] IDLE_TX = 8'hFF;

  typedef enum logic [2:0] {S_IDLE, S_E0, S_E1, S_E2, S_COPY, S_DONE, S_HOLD} st_t;
  st_t st;

  logic [AW-1:0] addr_q;
  logic [OW-1:0] ptr_q, end_q;
  logic          last;

  assign busy     = (st == S_COPY);
  assign mem_we   = busy;
  assign mem_addr = addr_q;
  assign sp_addr  = ptr_q;
  assign mem_data = sp_data;
  assign last     = busy && (ptr_q == end_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      auth_ok  <= 1'b0;
      addr_q   <= '0;
      ptr_q    <= '0;
      end_q    <= '0;
      tx_valid <= 1'b0;
      tx_byte  <= IDLE_TX;
    end else begin
      tx_valid <= tx_req;
      if (tx_req) tx_byte <= (st == S_DONE) ? PATTERN : IDLE_TX;
      if (sp_wr_cmd && !busy) auth_ok <= 1'b0;
      if (bus_reset && !busy) st <= S_IDLE;
      else begin
        case (st)
          S_IDLE: if (rx_valid) st <= (rx_byte == CMD_CODE) ? S_E0 : S_HOLD;
          S_E0:   if (rx_valid) st <= (rx_byte == tgt_lo) ? S_E1 : S_HOLD;
          S_E1:   if (rx_valid) st <= (rx_byte == tgt_hi) ? S_E2 : S_HOLD;
          S_E2:   if (rx_valid) begin
            if (rx_byte == {auth_ok, es_reg}) begin
              st      <= S_COPY;
              auth_ok <= 1'b1;
              addr_q  <= AW'({tgt_hi, tgt_lo});
              ptr_q   <= tgt_lo[OW-1:0];
              end_q   <= es_reg[OW-1:0];
            end else st <= S_HOLD;
          end
          S_COPY: begin
            addr_q <= addr_q + 1'b1;
            ptr_q  <= ptr_q + 1'b1;
            if (last) st <= S_DONE;
          end
          default: ;
        endcase
      end
    end
  end

  AST_LOCKOUT:    assert property (@(posedge clk) disable iff (!rst_n) busy && !last |=> busy); // R6
  AST_ADDR_STEP:  assert property (@(posedge clk) disable iff (!rst_n) busy && !last |=> mem_addr == $past(mem_addr) + 1'b1); // R5
  AST_COPY_ENDS:  assert property (@(posedge clk) disable iff (!rst_n) last |=> !busy); // R5
  AST_BUSY_FLAG:  assert property (@(posedge clk) disable iff (!rst_n) busy |-> auth_ok); // R4
  AST_FLAG_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) auth_ok && !sp_wr_cmd |=> auth_ok); // R8
  AST_TX_ECHO:    assert property (@(posedge clk) disable iff (!rst_n) tx_req |=> tx_valid); // R7
endmodule

// File: tb/copy_auth_ctrl_tb_top.sv
module copy_auth_ctrl_tb_top;
  logic clk = 0, rst_n = 0, bus_reset = 0, rx_valid = 0, tx_req = 0, sp_wr_cmd = 0;
  logic [7:0] rx_byte = 0, tgt_lo = 0, tgt_hi = 0;
  logic [6:0] es_reg = 0;
  logic tx_valid, mem_we, busy, auth_ok;
  logic [7:0] tx_byte, mem_data, sp_data;
  logic [4:0] sp_addr;
  logic [15:0] mem_addr;

  always #4 clk = ~clk;

  logic [7:0] sp_mem [32];
  assign sp_data = sp_mem[sp_addr];

  copy_auth_ctrl dut_i (.*);

  int wr_cnt = 0;
  logic [15:0] wr_addr [64];
  logic [7:0]  wr_data [64];
  always @(negedge clk) if (mem_we) begin
    if (wr_cnt < 64) begin wr_addr[wr_cnt] = mem_addr; wr_data[wr_cnt] = mem_data; end
    wr_cnt = wr_cnt + 1;
  end

  int nchk = 0, nfail = 0;
  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin nfail++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_byte = b;
    @(negedge clk); rx_valid = 0;
  endtask
  task automatic pulse_bus_reset(); @(negedge clk); bus_reset = 1; @(negedge clk); bus_reset = 0; endtask
  task automatic pulse_spw();       @(negedge clk); sp_wr_cmd = 1; @(negedge clk); sp_wr_cmd = 0; endtask
  task automatic read_tx(input string req, input logic [7:0] exp);
    @(negedge clk); tx_req = 1; @(negedge clk); tx_req = 0;
    chk({req, " tx_valid"}, tx_valid, 1);
    chk({req, " tx_byte"}, tx_byte, exp);
  endtask
  task automatic check_copy(input string req, input int n, input logic [15:0] base, input logic [4:0] st);
    int bad = 0;
    chk({req, " write count"}, wr_cnt, n);
    for (int k = 0; k < n && k < 64; k++) begin
      if (wr_addr[k] != base + 16'(k)) bad++;
      if (wr_data[k] != sp_mem[5'(st + 5'(k))]) bad++;
    end
    chk({req, " write addr/data"}, bad, 0);
  endtask

  // tgt_lo, tgt_hi, es_reg, echo0, echo1, echo2, copy length, expected flag
  typedef struct packed { logic [7:0] lo, hi; logic [6:0] es; logic [7:0] e0, e1, e2; logic [7:0] n; logic aa; } vec_t;
  localparam vec_t VT [9] = '{
    '{8'h40, 8'h00, 7'h1F, 8'h40, 8'h00, 8'h1F, 8'd32, 1'b1},
    '{8'h34, 8'h12, 7'h17, 8'h34, 8'h12, 8'h17, 8'd4,  1'b1},
    '{8'h05, 8'h00, 7'h05, 8'h05, 8'h00, 8'h05, 8'd1,  1'b1},
    '{8'h1E, 8'h07, 7'h01, 8'h1E, 8'h07, 8'h01, 8'd4,  1'b1},
    '{8'hFF, 8'hFF, 7'h1F, 8'hFF, 8'hFF, 8'h1F, 8'd1,  1'b1},
    '{8'h02, 8'h30, 7'h63, 8'h02, 8'h30, 8'h63, 8'd2,  1'b1},
    '{8'h10, 8'h00, 7'h12, 8'h11, 8'h00, 8'h12, 8'd0,  1'b0},
    '{8'h10, 8'h00, 7'h12, 8'h10, 8'h01, 8'h12, 8'd0,  1'b0},
    '{8'h10, 8'h00, 7'h12, 8'h10, 8'h00, 8'h92, 8'd0,  1'b0}
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) sp_mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0); chk("R1 auth_ok", auth_ok, 0);
    chk("R1 mem_we", mem_we, 0); chk("R1 tx_valid", tx_valid, 0);
    rst_n = 1;

    foreach (VT[i]) begin
      string tag = (VT[i].n != 0) ? "R5" : "R3";
      pulse_bus_reset(); pulse_spw();
      tgt_lo = VT[i].lo; tgt_hi = VT[i].hi; es_reg = VT[i].es;
      wr_cnt = 0;
      send(8'h55); send(VT[i].e0); send(VT[i].e1); send(VT[i].e2);
      repeat (40) @(negedge clk);
      check_copy(tag, VT[i].n, {VT[i].hi, VT[i].lo}, VT[i].lo[4:0]);
      chk("R4 auth_ok", auth_ok, VT[i].aa);
      read_tx("R7", (VT[i].n != 0) ? 8'hAA : 8'hFF);
    end

    // R2: wrong command code blocks a correct echo
    pulse_bus_reset(); pulse_spw();
    tgt_lo = 8'h03; tgt_hi = 8'h00; es_reg = 7'h04; wr_cnt = 0;
    send(8'hF0); send(8'h03); send(8'h00); send(8'h04);
    repeat (10) @(negedge clk);
    chk("R2 no writes", wr_cnt, 0);
    chk("R2 auth_ok", auth_ok, 0);

    // R4 and R6: busy timing, then bus reset during copy is ignored
    pulse_bus_reset();
    tgt_lo = 8'h00; tgt_hi = 8'h02; es_reg = 7'h1F; wr_cnt = 0;
    send(8'h55); send(8'h00); send(8'h02);
    @(negedge clk); rx_valid = 1; rx_byte = 8'h1F;
    @(negedge clk); rx_valid = 0;
    chk("R4 busy after match", busy, 1);
    repeat (3) @(negedge clk);
    bus_reset = 1; sp_wr_cmd = 1; @(negedge clk); bus_reset = 0; sp_wr_cmd = 0;
    repeat (40) @(negedge clk);
    check_copy("R6", 32, 16'h0200, 5'd0);
    chk("R8 clear ignored while busy", auth_ok, 1);
    read_tx("R7", 8'hAA);
    read_tx("R7 repeat", 8'hAA);

    // R8: sticky across bus reset; R9: flag bit in echo
    pulse_bus_reset();
    chk("R8 sticky", auth_ok, 1);
    read_tx("R7 after bus reset", 8'hFF);
    tgt_lo = 8'h08; tgt_hi = 8'h00; es_reg = 7'h08; wr_cnt = 0;
    send(8'h55); send(8'h08); send(8'h00); send(8'h08);
    repeat (6) @(negedge clk);
    chk("R9 bit7 clear rejected", wr_cnt, 0);
    pulse_bus_reset(); wr_cnt = 0;
    send(8'h55); send(8'h08); send(8'h00); send(8'h88);
    repeat (6) @(negedge clk);
    check_copy("R9", 1, 16'h0008, 5'd8);
    pulse_spw();
    chk("R8 cleared", auth_ok, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule